// File: doc/BRIEF.md
# Rotating Per-Task Register Context Ring

This block keeps the programmer-visible registers of a small 8-bit processor once for every task it runs. The copies sit in a circular ring, and only the copy at the head position drives the processor datapath. The datapath therefore reads and writes one fixed set of registers, and which task is active has no effect on how it behaves.

To change tasks, the scheduler names a target task and pulses a request. On each later clock the ring moves by one position until the target's copy reaches the head. A busy flag is high while the ring is moving. A task index output tells which task currently owns the head. The time a switch takes equals the forward distance around the ring from the current task to the target. A switch to the next task in ring order takes one cycle.

Top module: `ctx_ring`

## Requirements
- R1: Each task owns its own register set: accumulator (8 bits), index (8 bits), status (5 bits), stack pointer (5 bits) and program counter (12 bits). A value written while one task is at the head never appears while another task is at the head.
- R2: While `busy` is high, the ring advances by exactly one task per clock, and `cur_task` steps by one, wrapping from NTASK-1 to 0. While `busy` is low, `cur_task` holds its value.
- R3: A write strobe asserted while `busy` is low loads its data input into that field of the head copy at the clock edge. The `head_*` outputs always show the head copy.
- R4: After a request is accepted, `busy` stays high for exactly (target - current) mod NTASK cycles. With NTASK = 7, a switch from task 0 to task 6 holds `busy` for 6 cycles.
- R5: A request for the next task in ring order holds `busy` high for exactly one cycle.
- R6: Write strobes asserted while `busy` is high have no effect on any copy.
- R7: A request is accepted only when `busy` is low and `sw_task` < NTASK. Any other request is ignored.
- R8: After reset, every field of every copy is zero, `cur_task` is 0 and `busy` is low.
- R9: A request naming the task already at the head causes no rotation and never raises `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_a | input | 1 | Write strobe, accumulator |
| wr_x | input | 1 | Write strobe, index register |
| wr_ccr | input | 1 | Write strobe, status register |
| wr_sp | input | 1 | Write strobe, stack pointer |
| wr_pc | input | 1 | Write strobe, program counter |
| din_a | input | 8 | Accumulator write data |
| din_x | input | 8 | Index write data |
| din_ccr | input | 5 | Status write data |
| din_sp | input | 5 | Stack pointer write data |
| din_pc | input | 12 | Program counter write data |
| sw_req | input | 1 | Switch request pulse |
| sw_task | input | TW | Target task index |
| head_a | output | 8 | Head accumulator |
| head_x | output | 8 | Head index register |
| head_ccr | output | 5 | Head status register |
| head_sp | output | 5 | Head stack pointer |
| head_pc | output | 12 | Head program counter |
| busy | output | 1 | Rotation in progress |
| cur_task | output | TW | Task owning the head copy |

## Verification
The assertions assume that `sw_task` and the write strobes are stable from one falling edge to the next. They also assume that a write-data check is only meaningful when no request is accepted on the same edge. The stimulus changes inputs only on falling edges and holds them for a whole cycle. The directed requests cover every distance case: the next task, the longest wrap, the current task, an out-of-range index, and a request made while busy. A random phase then drives arbitrary strobes and task indices, including values at or above NTASK, and compares every cycle against a per-task reference model.

// File: rtl/ctx_ring_pkg.sv
package ctx_ring_pkg;
  localparam int A_W  = 8;
  localparam int X_W  = 8;
  localparam int CC_W = 5;
  localparam int SP_W = 5;
  localparam int PC_W = 12;

  typedef struct packed {
    logic [PC_W-1:0] pc;
    logic [SP_W-1:0] sp;
    logic [CC_W-1:0] ccr;
    logic [X_W-1:0]  x;
    logic [A_W-1:0]  a;
  } ctx_t;

  // next position around a ring of n tasks
  function automatic int unsigned wrap_inc(input int unsigned idx, input int unsigned n);
    return (idx + 1 >= n) ? 0 : idx + 1;
  endfunction

  // forward distance from one task to another around the ring
  function automatic int unsigned ring_dist(input int unsigned from, input int unsigned to,
                                            input int unsigned n);
    return (to >= from) ? (to - from) : (to + n - from);
  endfunction
endpackage

// File: rtl/ctx_slot.sv
module ctx_slot
  import ctx_ring_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic rot_en,
  input  ctx_t rot_in,
  input  logic ld_en,
  input  ctx_t ld_in,
  output ctx_t q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= '0;
    else if (rot_en) q <= rot_in;
    else if (ld_en)  q <= ld_in;
  end
endmodule

// File: rtl/ctx_seq.sv
module ctx_seq
  import ctx_ring_pkg::*;
#(
  parameter int NTASK = 7,
  parameter int TW    = (NTASK > 2) ? $clog2(NTASK) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sw_req,
  input  logic [TW-1:0] sw_task,
  output logic [TW-1:0] cur_task,
  output logic          busy,
  output logic          rotate,
  output logic          accept
);
  logic [TW-1:0] tgt_q;
  logic          in_range;

  assign in_range = int'(sw_task) < NTASK;
  assign busy     = (cur_task != tgt_q);
  assign rotate   = busy;
  assign accept   = sw_req && !busy && in_range;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_task <= '0;
      tgt_q    <= '0;
    end else begin
      if (rotate)
        cur_task <= TW'(wrap_inc(int'(cur_task), NTASK));
      if (accept)
        tgt_q <= sw_task;
    end
  end
endmodule

// File: rtl/ctx_ring.sv
module ctx_ring
  import ctx_ring_pkg::*;
#(
  parameter int NTASK = 7,
  localparam int TW   = (NTASK > 2) ? $clog2(NTASK) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_a,
  input  logic            wr_x,
  input  logic            wr_ccr,
  input  logic            wr_sp,
  input  logic            wr_pc,
  input  logic [A_W-1:0]  din_a,
  input  logic [X_W-1:0]  din_x,
  input  logic [CC_W-1:0] din_ccr,
  input  logic [SP_W-1:0] din_sp,
  input  logic [PC_W-1:0] din_pc,
  input  logic            sw_req,
  input  logic [TW-1:0]   sw_task,
  output logic [A_W-1:0]  head_a,
  output logic [X_W-1:0]  head_x,
  output logic [CC_W-1:0] head_ccr,
  output logic [SP_W-1:0] head_sp,
  output logic [PC_W-1:0] head_pc,
  output logic            busy,
  output logic [TW-1:0]   cur_task
);
  ctx_t slot_q [NTASK];
  ctx_t wr_ctx;
  logic rotate;
  logic accept;
  logic wr_any;
  logic wr_go;

  ctx_seq #(.NTASK(NTASK), .TW(TW)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .sw_req   (sw_req),
    .sw_task  (sw_task),
    .cur_task (cur_task),
    .busy     (busy),
    .rotate   (rotate),
    .accept   (accept)
  );

  assign wr_any = wr_a | wr_x | wr_ccr | wr_sp | wr_pc;
  assign wr_go  = wr_any && !busy;

  always_comb begin
    wr_ctx = slot_q[0];
    if (wr_a)   wr_ctx.a   = din_a;
    if (wr_x)   wr_ctx.x   = din_x;
    if (wr_ccr) wr_ctx.ccr = din_ccr;
    if (wr_sp)  wr_ctx.sp  = din_sp;
    if (wr_pc)  wr_ctx.pc  = din_pc;
  end

  for (genvar g = 0; g < NTASK; g++) begin : g_slot
    localparam int NXT = (g + 1) % NTASK;
    if (g == 0) begin : g_head
      ctx_slot u_slot (
        .clk(clk), .rst_n(rst_n), .rot_en(rotate), .rot_in(slot_q[NXT]),
        .ld_en(wr_go), .ld_in(wr_ctx), .q(slot_q[g])
      );
    end else begin : g_body
      ctx_slot u_slot (
        .clk(clk), .rst_n(rst_n), .rot_en(rotate), .rot_in(slot_q[NXT]),
        .ld_en(1'b0), .ld_in(wr_ctx), .q(slot_q[g])
      );
    end
  end

  assign head_a   = slot_q[0].a;
  assign head_x   = slot_q[0].x;
  assign head_ccr = slot_q[0].ccr;
  assign head_sp  = slot_q[0].sp;
  assign head_pc  = slot_q[0].pc;
endmodule

// File: rtl/ctx_ring_chk.sv
module ctx_ring_chk
  import ctx_ring_pkg::*;
#(
  parameter int NTASK = 7,
  parameter int TW    = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           busy,
  input logic           rotate,
  input logic           accept,
  input logic [TW-1:0]  cur_task,
  input logic [TW-1:0]  sw_task,
  input logic           wr_a,
  input logic           wr_any,
  input logic [A_W-1:0] din_a,
  input logic [A_W-1:0] head_a,
  input logic [PC_W-1:0] head_pc
);
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> int'(cur_task) == ((int'($past(cur_task)) == NTASK-1) ? 0 : int'($past(cur_task)) + 1)); // R2

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(cur_task)); // R2

  AST_CUR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cur_task) < NTASK); // R2

  AST_HEAD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && wr_a) |=> head_a == $past(din_a)); // R3

  AST_HEAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !wr_any) |=> ($stable(head_a) && $stable(head_pc))); // R3

  AST_NEXT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && int'(sw_task) == int'(wrap_inc(int'(cur_task), NTASK))) |=> busy ##1 !busy); // R5

  AST_BUSY_BLOCKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !accept); // R7

  AST_SAME_NO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && sw_task == cur_task) |=> !busy); // R9

  AST_IDLE_NO_ROTATE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !accept) |=> !rotate); // R9
endmodule

bind ctx_ring ctx_ring_chk #(.NTASK(NTASK), .TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .rotate(rotate), .accept(accept),
  .cur_task(cur_task), .sw_task(sw_task), .wr_a(wr_a), .wr_any(wr_any),
  .din_a(din_a), .head_a(head_a), .head_pc(head_pc)
);

// File: tb/tb_ctx_ring.sv
`timescale 1ns/1ps
module tb_ctx_ring;
  localparam int NT = 7;
  localparam int TW = 3;

  logic clk = 0;
  logic rst_n = 0;
  logic wr_a = 0, wr_x = 0, wr_ccr = 0, wr_sp = 0, wr_pc = 0;
  logic [7:0]  din_a = 0, din_x = 0;
  logic [4:0]  din_ccr = 0, din_sp = 0;
  logic [11:0] din_pc = 0;
  logic sw_req = 0;
  logic [TW-1:0] sw_task = 0;
  logic [7:0]  head_a, head_x;
  logic [4:0]  head_ccr, head_sp;
  logic [11:0] head_pc;
  logic busy;
  logic [TW-1:0] cur_task;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ctx_ring #(.NTASK(NT)) dut (
    .clk(clk), .rst_n(rst_n),
    .wr_a(wr_a), .wr_x(wr_x), .wr_ccr(wr_ccr), .wr_sp(wr_sp), .wr_pc(wr_pc),
    .din_a(din_a), .din_x(din_x), .din_ccr(din_ccr), .din_sp(din_sp), .din_pc(din_pc),
    .sw_req(sw_req), .sw_task(sw_task),
    .head_a(head_a), .head_x(head_x), .head_ccr(head_ccr), .head_sp(head_sp),
    .head_pc(head_pc), .busy(busy), .cur_task(cur_task)
  );

  // reference model: storage indexed by task id, an active task and a goal
  int m_a [NT];
  int m_x [NT];
  int m_cc [NT];
  int m_sp [NT];
  int m_pc [NT];
  int m_cur = 0;
  int m_goal = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NT; i++) begin
        m_a[i] = 0; m_x[i] = 0; m_cc[i] = 0; m_sp[i] = 0; m_pc[i] = 0;
      end
      m_cur = 0; m_goal = 0;
    end else if (m_cur != m_goal) begin
      m_cur = (m_cur + 1) % NT;
    end else begin
      if (wr_a)   m_a[m_cur]  = din_a;
      if (wr_x)   m_x[m_cur]  = din_x;
      if (wr_ccr) m_cc[m_cur] = din_ccr;
      if (wr_sp)  m_sp[m_cur] = din_sp;
      if (wr_pc)  m_pc[m_cur] = din_pc;
      if (sw_req && int'(sw_task) < NT) m_goal = sw_task;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(int'(cur_task) == m_cur, "R2 cur_task", cur_task, m_cur);
      chk(busy == (m_cur != m_goal), "R4 busy", busy, m_cur != m_goal);
      chk(int'(head_a)   == m_a[m_cur],  "R1/R3/R6 head_a",   head_a,   m_a[m_cur]);
      chk(int'(head_x)   == m_x[m_cur],  "R1/R3/R6 head_x",   head_x,   m_x[m_cur]);
      chk(int'(head_ccr) == m_cc[m_cur], "R1/R3/R6 head_ccr", head_ccr, m_cc[m_cur]);
      chk(int'(head_sp)  == m_sp[m_cur], "R1/R3/R6 head_sp",  head_sp,  m_sp[m_cur]);
      chk(int'(head_pc)  == m_pc[m_cur], "R1/R3/R6 head_pc",  head_pc,  m_pc[m_cur]);
    end
  end

  task automatic put_all(input int seed);
    wr_a = 1; wr_x = 1; wr_ccr = 1; wr_sp = 1; wr_pc = 1;
    din_a = 8'(seed * 3 + 1); din_x = 8'(seed * 5 + 2);
    din_ccr = 5'(seed + 7); din_sp = 5'(seed * 2 + 3); din_pc = 12'(seed * 97 + 11);
    @(negedge clk);
    wr_a = 0; wr_x = 0; wr_ccr = 0; wr_sp = 0; wr_pc = 0;
  endtask

  // request a switch and measure how many cycles busy stays high
  task automatic do_switch(input int tgt, input int exp_lat, input int exp_cur, input string tag);
    int lat;
    sw_req = 1; sw_task = TW'(tgt);
    @(negedge clk);
    sw_req = 0;
    lat = 0;
    while (busy && lat < 20) begin
      lat++;
      @(negedge clk);
    end
    chk(lat == exp_lat, tag, lat, exp_lat);
    chk(int'(cur_task) == exp_cur, tag, cur_task, exp_cur);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8: reset state
    chk(busy == 0, "R8 busy", busy, 0);
    chk(cur_task == 0, "R8 cur_task", cur_task, 0);
    chk(head_a == 0 && head_x == 0 && head_pc == 0, "R8 head", head_pc, 0);
    rst_n = 1;
    @(negedge clk);
    put_all(1);                              // R3 task 0
    do_switch(1, 1, 1, "R5 next task");
    put_all(2);                              // R1 task 1
    chk(head_a == 8'(2 * 3 + 1), "R3 head_a after write", head_a, 2 * 3 + 1);
    do_switch(0, 6, 0, "R4 wrap 1->0");
    chk(head_a == 8'(1 * 3 + 1), "R1 task0 kept", head_a, 4);
    do_switch(0, 0, 0, "R9 same task");
    do_switch(6, 6, 6, "R4 0->6 latency");
    chk(head_a == 0, "R1 task6 untouched", head_a, 0);
    do_switch(0, 1, 0, "R5 6->0 wrap next");
    do_switch(7, 0, 0, "R7 out of range");
    // R6: writes while busy are dropped; R7: request while busy ignored
    sw_req = 1; sw_task = 3;
    @(negedge clk);
    sw_task = 1; wr_a = 1; din_a = 8'hEE; wr_pc = 1; din_pc = 12'hABC;
    @(negedge clk);
    sw_req = 0;
    @(negedge clk);
    wr_a = 0; wr_pc = 0;
    while (busy) @(negedge clk);
    chk(cur_task == 3, "R7 request during busy ignored", cur_task, 3);
    chk(head_a == 0, "R6 task3 untouched", head_a, 0);
    do_switch(1, 5, 1, "R4 3->1");
    chk(head_a == 8'(2 * 3 + 1), "R6 task1 untouched", head_a, 7);
    // random phase, compared every cycle by the model
    for (int k = 0; k < 3000; k++) begin
      wr_a = 1'($urandom); wr_x = 1'($urandom); wr_ccr = 1'($urandom);
      wr_sp = 1'($urandom); wr_pc = 1'($urandom);
      din_a = 8'($urandom); din_x = 8'($urandom); din_ccr = 5'($urandom);
      din_sp = 5'($urandom); din_pc = 12'($urandom);
      sw_req = ($urandom % 4) == 0; sw_task = TW'($urandom);
      @(negedge clk);
    end
    wr_a = 0; wr_x = 0; wr_ccr = 0; wr_sp = 0; wr_pc = 0; sw_req = 0;
    repeat (10) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule